// File: doc/BRIEF.md
# Parallel ADC Conversion and Readout Sequencer

This block sits on the host side of a 16-bit sampling converter that has a parallel output. It generates the converter's active-low strobes: conversion start, chip select, read, and a byte-select line. It follows the converter's BUSY output. It takes each result off the shared data bus and hands it downstream as one word on a valid/ready stream. Every timing minimum the converter needs is given as a nanosecond parameter. Each one becomes a cycle count at elaboration, rounded up against the clock period parameter.

A conversion starts when `start_req` is high while the sequencer is idle and no earlier sample is still waiting. The result can come back in one of two ways. The first is a single 16-bit read. The second is a pair of reads over the low 8 bus lines: the high byte comes first and the low byte second, and the two are joined into one word. A pulse on `abort_req` ends a conversion with a second start edge, but only while the elapsed time since the start edge lies inside the permitted abort window. If BUSY does not fall within the maximum conversion time plus a margin, the sequencer raises a one-cycle timeout flag and releases the bus.

The output follows valid/ready rules. `smp_valid` stays high and `smp_data` stays unchanged until a cycle in which `smp_ready` is high. No new conversion starts while a sample is still waiting, so downstream back-pressure stalls sampling rather than dropping data.

Top module: `adc_seq`

## Requirements
- R1: After reset, `conv_n`, `cs_n` and `rd_n` are high, `byte_sel` is 0 and `smp_valid` is 0.
- R2: Each `conv_n` low pulse lasts at least 4 cycles, and each high interval between two low pulses lasts at least 4 cycles.
- R3: `rd_n` falls only while `cs_n` is low and `adc_busy` is low, and no earlier than 82 cycles after the latest `conv_n` falling edge.
- R4: Each `rd_n` low pulse lasts at least 10 cycles.
- R5: With `byte_mode`=0 there is one read per conversion, and `smp_data` equals the 16-bit bus value seen during that read.
- R6: With `byte_mode`=1 there are two reads. The first has `byte_sel`=0 and takes `adc_bus[7:0]` as result bits 15:8. The second has `byte_sel`=1, follows the `byte_sel` change by at least 10 cycles, and takes `adc_bus[7:0]` as bits 7:0. `adc_bus[15:8]` is ignored.
- R7: A `conv_n` falling edge comes at least 10 cycles after the last `rd_n` rising edge, and `cs_n` stays high for at least 4 cycles before it falls again.
- R8: While `smp_valid` is 1 and `smp_ready` is 0, `smp_data` holds its value. `smp_valid` clears after a cycle with `smp_ready`=1. No `conv_n` falling edge occurs while `smp_valid` is 1, even if `start_req` is held high.
- R9: An `abort_req` pulse sampled while BUSY is awaited, and while the second start edge would fall 12 to 68 cycles after the conversion's start edge, causes a second `conv_n` low pulse. That conversion then produces no sample, and the strobes return high.
- R10: An `abort_req` pulse outside that window is ignored, and the conversion delivers its sample normally.
- R11: If `adc_busy` has not both risen and fallen within 100 cycles of the start edge, `busy_timeout` pulses, no sample is produced, and the strobes return high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request a conversion, accepted only when idle |
| abort_req | input | 1 | Request abort of the conversion in progress |
| byte_mode | input | 1 | 0: one 16-bit read; 1: two 8-bit reads |
| adc_busy | input | 1 | Converter BUSY, high while converting |
| adc_bus | input | 16 | Converter data bus |
| conv_n | output | 1 | Active-low conversion start strobe |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| byte_sel | output | 1 | 0: high byte on bus[7:0]; 1: low byte |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Downstream accepts the sample |
| smp_data | output | 16 | Assembled sample |
| busy_timeout | output | 1 | One-cycle pulse when BUSY does not finish in time |

## Verification
Some properties are checked on every cycle: the minimum widths of the start and read pulses, that a read only happens inside chip select and while BUSY is low, that a waiting sample stays stable, and that no start edge falls while a sample is waiting. Other behaviour can only be shown by the bench's scenarios against its converter model. These are the byte ordering and word assembly, the read-after-start delay and the release-to-start gap, the accept-or-ignore decision for an abort depending on when it arrives, and the timeout path when the converter never answers.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START_LOW,
    S_START_HIGH,
    S_WAIT_BUSY_HI,
    S_WAIT_BUSY_LO,
    S_CS_SETUP,
    S_READ_LOW,
    S_READ_HIGH,
    S_BYTE_SWITCH,
    S_RELEASE,
    S_HOLDOFF
  } seq_state_e;

  // ceiling division of a nanosecond minimum by the clock period
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned mx(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_cnt.sv
// Saturating up-counter with synchronous clear.
module adc_seq_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (clr)        q <= '0;
    else if (q != '1)    q <= q + 1'b1;
  end
endmodule

// File: rtl/adc_seq_pack.sv
// Gathers bus data into a word and holds it on the valid/ready output.
module adc_seq_pack #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          byte_mode,
  input  logic          lo_phase,
  input  logic [DW-1:0] bus,
  input  logic          give,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data
);
  localparam int HW = DW / 2;

  logic [DW-1:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (cap_en) begin
      if (!byte_mode)    acc          <= bus;
      else if (!lo_phase) acc[DW-1:HW] <= bus[HW-1:0];
      else               acc[HW-1:0]  <= bus[HW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (give) begin
      valid <= 1'b1;
      data  <= acc;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DW             = 16,
  parameter int unsigned CLK_NS         = 5,
  parameter int unsigned T_CONV_LO_NS   = 20,
  parameter int unsigned T_CONV_HI_NS   = 20,
  parameter int unsigned T_RD_LO_NS     = 50,
  parameter int unsigned T_RD_HI_NS     = 20,
  parameter int unsigned T_EN_NS        = 20,
  parameter int unsigned T_CS_HI_NS     = 20,
  parameter int unsigned T_BYTE_NS      = 50,
  parameter int unsigned T_RD2CONV_NS   = 50,
  parameter int unsigned T_ABORT_MIN_NS = 60,
  parameter int unsigned T_ABORT_MAX_NS = 340,
  parameter int unsigned T_CONV_MAX_NS  = 400,
  parameter int unsigned T_MSB_NS       = 10,
  parameter int unsigned T_WD_MARGIN_NS = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          abort_req,
  input  logic          byte_mode,
  input  logic          adc_busy,
  input  logic [DW-1:0] adc_bus,
  output logic          conv_n,
  output logic          cs_n,
  output logic          rd_n,
  output logic          byte_sel,
  output logic          smp_valid,
  input  logic          smp_ready,
  output logic [DW-1:0] smp_data,
  output logic          busy_timeout
);
  localparam int unsigned C_LO    = ns_to_cyc(T_CONV_LO_NS, CLK_NS);
  localparam int unsigned C_HI    = ns_to_cyc(T_CONV_HI_NS, CLK_NS);
  localparam int unsigned C_RDLO  = mx(ns_to_cyc(T_RD_LO_NS, CLK_NS), ns_to_cyc(T_EN_NS, CLK_NS));
  localparam int unsigned C_RDHI  = ns_to_cyc(T_RD_HI_NS, CLK_NS);
  localparam int unsigned C_BYTE  = mx(ns_to_cyc(T_BYTE_NS, CLK_NS), ns_to_cyc(T_EN_NS, CLK_NS));
  localparam int unsigned C_OFF   = mx(ns_to_cyc(T_RD2CONV_NS, CLK_NS), ns_to_cyc(T_CS_HI_NS, CLK_NS));
  localparam int unsigned C_ABMIN = ns_to_cyc(T_ABORT_MIN_NS, CLK_NS);
  localparam int unsigned C_ABMAX = T_ABORT_MAX_NS / CLK_NS;
  localparam int unsigned C_RDOK  = ns_to_cyc(T_CONV_MAX_NS + T_MSB_NS, CLK_NS);
  localparam int unsigned C_WD    = ns_to_cyc(T_CONV_MAX_NS + T_WD_MARGIN_NS, CLK_NS);
  localparam int unsigned C_TOP   = mx(mx(C_WD, C_RDOK), mx(C_ABMAX, mx(C_OFF, C_BYTE)));
  localparam int          CW      = $clog2(C_TOP + 2);

  localparam logic [CW-1:0] L_LO    = CW'(C_LO - 1);
  localparam logic [CW-1:0] L_HI    = CW'(C_HI - 1);
  localparam logic [CW-1:0] L_RDLO  = CW'(C_RDLO - 1);
  localparam logic [CW-1:0] L_RDHI  = CW'(C_RDHI - 1);
  localparam logic [CW-1:0] L_BYTE  = CW'(C_BYTE - 1);
  localparam logic [CW-1:0] L_OFF   = CW'(C_OFF - 1);
  localparam logic [CW-1:0] L_ABMIN = CW'(C_ABMIN - 1);  // edge lands one cycle after decision
  localparam logic [CW-1:0] L_ABMAX = CW'(C_ABMAX - 1);
  localparam logic [CW-1:0] L_RDOK  = CW'(C_RDOK);
  localparam logic [CW-1:0] L_WD    = CW'(C_WD);

  seq_state_e    state, state_n;
  logic [CW-1:0] cnt, ccnt;
  logic          mode_q, lo_phase, aborting;
  logic          cap_en, give, timeout, ab_set, abort_hit;

  // cnt: cycles spent in the current state; ccnt: cycles since start edge
  adc_seq_cnt #(.W(CW)) u_phase (.clk(clk), .rst_n(rst_n), .clr(state_n != state), .q(cnt));
  adc_seq_cnt #(.W(CW)) u_conv  (.clk(clk), .rst_n(rst_n), .clr(state == S_IDLE),  .q(ccnt));

  assign abort_hit = abort_req && (ccnt >= L_ABMIN) && (ccnt <= L_ABMAX);

  always_comb begin
    state_n = state;
    cap_en  = 1'b0;
    give    = 1'b0;
    timeout = 1'b0;
    ab_set  = 1'b0;
    case (state)
      S_IDLE:         if (start_req && !smp_valid) state_n = S_START_LOW;
      S_START_LOW:    if (cnt == L_LO) state_n = aborting ? S_HOLDOFF : S_START_HIGH;
      S_START_HIGH:   if (cnt == L_HI) state_n = S_WAIT_BUSY_HI;
      S_WAIT_BUSY_HI: begin
        if (adc_busy) state_n = S_WAIT_BUSY_LO;
        else if (ccnt >= L_WD) begin
          timeout = 1'b1;
          state_n = S_HOLDOFF;
        end
      end
      S_WAIT_BUSY_LO: begin
        if (abort_hit) begin
          ab_set  = 1'b1;
          state_n = S_START_LOW;
        end else if (!adc_busy && ccnt >= L_RDOK) begin
          state_n = S_CS_SETUP;
        end else if (ccnt >= L_WD) begin
          timeout = 1'b1;
          state_n = S_HOLDOFF;
        end
      end
      S_CS_SETUP:     state_n = S_READ_LOW;
      S_READ_LOW: begin
        if (cnt == L_RDLO) begin
          cap_en  = 1'b1;
          state_n = (mode_q && !lo_phase) ? S_READ_HIGH : S_RELEASE;
        end
      end
      S_READ_HIGH:    if (cnt == L_RDHI) state_n = S_BYTE_SWITCH;
      S_BYTE_SWITCH:  if (cnt == L_BYTE) state_n = S_READ_LOW;
      S_RELEASE: begin
        give    = 1'b1;
        state_n = S_HOLDOFF;
      end
      S_HOLDOFF:      if (cnt == L_OFF) state_n = S_IDLE;
      default:        state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      mode_q       <= 1'b0;
      lo_phase     <= 1'b0;
      aborting     <= 1'b0;
      busy_timeout <= 1'b0;
    end else begin
      state        <= state_n;
      busy_timeout <= timeout;
      if (state == S_IDLE) begin
        mode_q   <= byte_mode;
        lo_phase <= 1'b0;
        aborting <= 1'b0;
      end else begin
        if (state == S_READ_HIGH && state_n == S_BYTE_SWITCH) lo_phase <= 1'b1;
        if (ab_set) aborting <= 1'b1;
      end
    end
  end

  assign conv_n   = (state != S_START_LOW);
  assign rd_n     = (state != S_READ_LOW);
  assign cs_n     = !(state inside {S_CS_SETUP, S_READ_LOW, S_READ_HIGH, S_BYTE_SWITCH, S_RELEASE});
  assign byte_sel = lo_phase;

  adc_seq_pack #(.DW(DW)) u_pack (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .byte_mode(mode_q), .lo_phase(lo_phase),
    .bus(adc_bus), .give(give), .ready(smp_ready), .valid(smp_valid), .data(smp_data)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int unsigned DW           = 16,
  parameter int unsigned CLK_NS       = 5,
  parameter int unsigned T_CONV_LO_NS = 20,
  parameter int unsigned T_RD_LO_NS   = 50
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_n,
  input logic          cs_n,
  input logic          rd_n,
  input logic          adc_busy,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic [DW-1:0] smp_data
);
  localparam logic [7:0] K_LO = 8'(ns_to_cyc(T_CONV_LO_NS, CLK_NS));
  localparam logic [7:0] K_RD = 8'(ns_to_cyc(T_RD_LO_NS, CLK_NS));

  logic [7:0] conv_run, rd_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_run <= '0;
      rd_run   <= '0;
    end else begin
      conv_run <= conv_n ? 8'd0 : ((conv_run == 8'hFF) ? conv_run : conv_run + 8'd1);
      rd_run   <= rd_n   ? 8'd0 : ((rd_run   == 8'hFF) ? rd_run   : rd_run   + 8'd1);
    end
  end

  p_conv_low_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_n && !$past(conv_n)) |-> (conv_run >= K_LO));

  p_rd_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);

  p_rd_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !adc_busy);

  p_rd_low_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && !$past(rd_n)) |-> (rd_run >= K_RD));

  p_hold_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)));

  p_no_start_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_n && $past(conv_n)) |-> !smp_valid);
endmodule

bind adc_seq adc_seq_chk #(
  .DW(DW), .CLK_NS(CLK_NS), .T_CONV_LO_NS(T_CONV_LO_NS), .T_RD_LO_NS(T_RD_LO_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .cs_n(cs_n), .rd_n(rd_n),
  .adc_busy(adc_busy), .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data)
);

// File: tb/test_adc_seq.sv
`timescale 1ns/1ps
module test_adc_seq;
  localparam int K_LO = 4, K_HI = 4, K_RDLO = 10, K_HOLD = 10, K_CSHI = 4, K_BYTE = 10;
  localparam int K_RDOK = (400 + 10 + 4) / 5;
  localparam int CONV_CYC = 74;  // converter model: 370 ns of BUSY
  localparam int EN_CYC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_req = 0, abort_req = 0, byte_mode = 0, smp_ready = 0;
  logic adc_busy;
  logic [15:0] adc_bus, smp_data;
  logic conv_n, cs_n, rd_n, byte_sel, smp_valid, busy_timeout;

  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  adc_seq i_adc_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .abort_req(abort_req),
    .byte_mode(byte_mode), .adc_busy(adc_busy), .adc_bus(adc_bus),
    .conv_n(conv_n), .cs_n(cs_n), .rd_n(rd_n), .byte_sel(byte_sel),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .busy_timeout(busy_timeout)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  logic [15:0] next_word = 16'h0, word_q = 16'h0;
  logic mute = 1'b0, conv_on = 1'b0, conv_d = 1'b1;
  int since = 0, rlow = 0, n_abort = 0;

  assign adc_busy = conv_on && (since >= 2);
  assign adc_bus = (!cs_n && !rd_n && rlow >= EN_CYC)
                 ? (byte_mode ? (byte_sel ? {8'h5A, word_q[7:0]} : {8'hA5, word_q[15:8]}) : word_q)
                 : 16'hBEEF;

  always @(posedge clk) begin
    conv_d <= conv_n;
    rlow   <= rd_n ? 0 : rlow + 1;
    if (since < 10000) since <= since + 1;
    if (conv_d && !conv_n && !mute) begin
      if (conv_on) begin
        chk(since >= 12 && since <= 68, "R9 abort edge inside window", since, 12);
        n_abort <= n_abort + 1;
        conv_on <= 1'b0;
      end else begin
        conv_on <= 1'b1;
        since   <= 0;
      end
    end else if (conv_on && since == CONV_CYC - 1) begin
      conv_on <= 1'b0;
      word_q  <= next_word;
    end
  end

  // ---------------- strobe timing monitor ----------------
  logic pconv = 1, prd = 1, pcs = 1, pbs = 0;
  int conv_lo_run = 0, conv_hi_run = 1000, rd_lo_run = 0, since_rd_rise = 1000;
  int cs_hi_run = 1000, bs_run = 1000, since_fall = 0, rd_idx = 0, n_falls = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pconv && !conv_n) begin
        chk(conv_hi_run >= K_HI, "R2 conv high gap", conv_hi_run, K_HI);
        chk(since_rd_rise >= K_HOLD, "R7 read-release to start gap", since_rd_rise, K_HOLD);
        n_falls++;
        since_fall = 0;
        rd_idx = 0;
      end
      if (!pconv && conv_n) chk(conv_lo_run >= K_LO, "R2 conv low width", conv_lo_run, K_LO);
      if (pcs && !cs_n) chk(cs_hi_run >= K_CSHI, "R7 cs high gap", cs_hi_run, K_CSHI);
      if (prd && !rd_n) begin
        chk(!cs_n && !adc_busy, "R3 read inside cs and after busy", {cs_n, adc_busy}, 0);
        chk(since_fall >= K_RDOK, "R3 read delay from start", since_fall, K_RDOK);
        if (byte_mode) begin
          chk(byte_sel == (rd_idx == 1), "R6 byte order", byte_sel, (rd_idx == 1));
          if (byte_sel) chk(bs_run >= K_BYTE, "R6 byte switch setup", bs_run, K_BYTE);
        end else begin
          chk(rd_idx == 0, "R5 single read per conversion", rd_idx, 0);
        end
        rd_idx++;
      end
      if (!prd && rd_n) begin
        chk(rd_lo_run >= K_RDLO, "R4 read low width", rd_lo_run, K_RDLO);
        since_rd_rise = 0;
      end
    end
    conv_lo_run   = conv_n ? 0 : conv_lo_run + 1;
    conv_hi_run   = conv_n ? conv_hi_run + 1 : 0;
    rd_lo_run     = rd_n ? 0 : rd_lo_run + 1;
    cs_hi_run     = cs_n ? cs_hi_run + 1 : 0;
    bs_run        = (byte_sel != pbs) ? 1 : bs_run + 1;
    since_rd_rise = since_rd_rise + 1;
    since_fall    = since_fall + 1;
    pconv = conv_n; prd = rd_n; pcs = cs_n; pbs = byte_sel;
  end

  // ---------------- scenarios ----------------
  function automatic logic [15:0] pat(int m, int i);
    if (i == 0)  return 16'h0000;
    if (i == 15) return 16'hFFFF;
    return 16'((i * 40503) ^ (m * 16'h3C3C));
  endfunction

  task automatic idle_check(input string tag);
    chk(conv_n && cs_n && rd_n && !smp_valid, tag, {conv_n, cs_n, rd_n, smp_valid}, 4'b1110);
  endtask

  task automatic do_sample(input int m, input int i, input int dly);
    logic [15:0] d0;
    int nf;
    byte_mode = m[0];
    next_word = pat(m, i);
    @(negedge clk) start_req = 1;
    for (int k = 0; k < 400 && !smp_valid; k++) @(negedge clk);
    chk(smp_valid, "R8 sample arrives", smp_valid, 1);
    nf = n_falls;
    d0 = smp_data;
    repeat (dly) @(negedge clk);
    chk(smp_valid && smp_data == d0, "R8 sample held under back-pressure", smp_data, d0);
    chk(n_falls == nf, "R8 no start while sample pending", n_falls, nf);
    chk(smp_data == pat(m, i), m ? "R6 byte assembly" : "R5 word read", smp_data, pat(m, i));
    start_req = 0;
    smp_ready = 1;
    @(negedge clk) smp_ready = 0;
    chk(!smp_valid, "R8 valid clears after handshake", smp_valid, 0);
  endtask

  task automatic abort_at(input int when, input bit hit);
    bit got = 0;
    int a0 = n_abort;
    byte_mode = 0;
    next_word = 16'h6C3A ^ 16'(when);
    @(negedge clk) start_req = 1;
    for (int k = 0; k < 50 && conv_n; k++) @(negedge clk);
    start_req = 0;
    repeat (when) @(negedge clk);
    abort_req = 1;
    @(negedge clk) abort_req = 0;
    for (int k = 0; k < 200 && !got; k++) begin
      got = smp_valid;
      @(negedge clk);
    end
    if (hit) begin
      chk(!got, "R9 aborted conversion yields no sample", got, 0);
      chk(n_abort == a0 + 1, "R9 second start edge issued", n_abort, a0 + 1);
      repeat (20) @(negedge clk);
      idle_check("R9 strobes released after abort");
    end else begin
      chk(got && smp_data == next_word, "R10 late/early abort ignored", smp_data, next_word);
      chk(n_abort == a0, "R10 no abort edge", n_abort, a0);
      smp_ready = 1;
      @(negedge clk) smp_ready = 0;
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_vec++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    bit tflag;
    repeat (4) @(negedge clk);
    chk(conv_n && cs_n && rd_n && !byte_sel && !smp_valid, "R1 reset state",
        {conv_n, cs_n, rd_n, byte_sel, smp_valid}, 5'b11100);
    rst_n = 1;
    repeat (3) @(negedge clk);
    idle_check("R1 idle after reset");

    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 16; i++)
        do_sample(m, i, (i % 4) * 7);

    abort_at(20, 1'b1);
    abort_at(5, 1'b0);
    abort_at(70, 1'b0);

    // converter never answers: watchdog path
    mute = 1;
    tflag = 0;
    @(negedge clk) start_req = 1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      start_req = 0;
      if (busy_timeout) tflag = 1;
      chk(!smp_valid, "R11 no sample on timeout", smp_valid, 0);
    end
    chk(tflag, "R11 timeout pulse", tflag, 1);
    idle_check("R11 strobes released after timeout");
    mute = 0;
    repeat (20) @(negedge clk);
    do_sample(1, 3, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule